// File: doc/BRIEF.md
# Interrupt Priority and Acceptance Unit

This block holds the per-vector interrupt state of one local interrupt controller: a request set, an in-service set and a trigger-mode set, each with one bit per vector. Vector arrivals come in on a delivery port with an edge or level flag. The block combines a task-priority value with the highest vector in service to form the processor priority. It raises a pending line to the CPU whenever the highest requested vector belongs to a higher priority class.

The CPU accepts an interrupt with a single-cycle acknowledge request. One cycle later the block answers with a granted vector, a programmable spurious vector, or a "nothing to deliver" status. An end-of-interrupt strobe retires the highest in-service vector. For level-triggered vectors it can produce a one-cycle broadcast pulse that carries the retired vector.

Top module: `intr_accept_unit`

## Requirements
- R1: Reset clears the request, in-service and trigger-mode sets and the task priority. It loads the control register with spurious vector 0xFF, software enable off and directed end-of-interrupt off. After reset `irq_pending` is 0, `ppr` is 0, and once software enable is on, an acknowledge reports `ack_none`.
- R2: A cycle with `arr_valid` high sets the request bit of `arr_vector` from the next cycle on. `arr_level`=1 sets the vector's trigger-mode bit.
- R3: The highest request or in-service vector is the numerically largest set vector. The search runs over 32-bit words from the top word down, taking the most significant set bit of the first non-empty word.
- R4: `ppr` equals the task priority when nothing is in service, or when the task priority's class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it equals that in-service vector with bits 3:0 cleared.
- R5: The highest request is priority-masked when `ppr` is nonzero and its class is less than or equal to the class of `ppr`. With `ppr`=0 no request is masked.
- R6: `irq_pending` is high exactly when software enable (control bit 8) is set and an unmasked request exists.
- R7: An acknowledge while a request qualifies gives, one cycle later, `ack_valid`=1, `ack_none`=0 and `ack_vector` equal to the highest request. That vector moves from the request set to the in-service set.
- R8: An acknowledge while requests exist but all are masked returns control bits 7:0 as `ack_vector` with `ack_none`=0 and changes no state.
- R9: An acknowledge with an empty request set, or with software enable clear, returns `ack_valid`=1 and `ack_none`=1 and changes no state.
- R10: An end-of-interrupt clears the highest in-service bit. If that vector's trigger-mode bit is set and directed end-of-interrupt (control bit 9) is clear, `eoi_bcast_valid` pulses for one cycle on the next cycle with that vector. With an empty in-service set it does nothing.
- R11: An arrival with `arr_level`=0 clears the vector's trigger-mode bit, so its end-of-interrupt gives no broadcast.
- R12: Vectors 0 to 15 are accepted and delivered like any other vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | Vector arrival strobe |
| arr_vector | input | 8 | Arriving vector |
| arr_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_data | input | 8 | Task-priority value |
| spur_wr | input | 1 | Control register write strobe |
| spur_data | input | 10 | [7:0] spurious vector, [8] software enable, [9] directed end-of-interrupt |
| ack_req | input | 1 | CPU acknowledge request |
| ack_valid | output | 1 | Acknowledge response valid (one cycle after request) |
| ack_none | output | 1 | No interrupt to deliver |
| ack_vector | output | 8 | Granted or spurious vector |
| eoi_wr | input | 1 | End-of-interrupt strobe |
| eoi_bcast_valid | output | 1 | End-of-interrupt broadcast pulse |
| eoi_bcast_vector | output | 8 | Vector carried by the broadcast |
| irq_pending | output | 1 | Interrupt pending to the CPU |
| ppr | output | 8 | Current processor priority |

## Verification
One table-driven sequence interleaves arrivals in different 32-bit words and in the same word. This separates the word-major scan order from a plain bit order, and its extremes 0x00 and 0xFF touch both ends of the scan. The task priority is moved above, equal to and below the in-service class, which tells the "task priority wins" branch of the processor priority apart from the "in-service class wins" branch. Acknowledges are issued in three states: with a qualifying request, with only masked requests, and with nothing requested or software disabled. These give the three distinct responses. End-of-interrupt is exercised for level and edge vectors with directed end-of-interrupt both off and on, and on an empty in-service set.

// File: rtl/iau_pkg.sv
package iau_pkg;

   // Outcome of one CPU acknowledge
   typedef enum logic [1:0] {
      ACK_GRANT = 2'd0,
      ACK_SPUR  = 2'd1,
      ACK_NONE  = 2'd2
   } ack_kind_e;

   // Control register bit positions
   localparam int CTL_EN_BIT  = 8;
   localparam int CTL_DIR_BIT = 9;
   localparam int CTL_W       = 10;

endpackage

// File: rtl/iau_hi_scan.sv
// Finds the highest set vector: word-major scan, MSB inside a word.
module iau_hi_scan #(
   parameter int NUM_VEC = 256,
   parameter int WORD_W  = 32
) (
   input  logic [NUM_VEC-1:0]         bits,
   output logic                       found,
   output logic [$clog2(NUM_VEC)-1:0] idx
);
   localparam int NWORDS = NUM_VEC / WORD_W;
   localparam int BIT_W  = $clog2(WORD_W);
   localparam int IDX_W  = $clog2(NUM_VEC);

   if ((NUM_VEC % WORD_W) != 0 || (1 << BIT_W) != WORD_W) begin : g_bad_cfg
      $error("iau_hi_scan: WORD_W must be a power of two dividing NUM_VEC");
   end

   logic [NWORDS-1:0]            word_hit;
   logic [NWORDS-1:0][BIT_W-1:0] word_pos;

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      logic [WORD_W-1:0] wbits;
      logic [BIT_W-1:0]  pos;
      assign wbits = bits[w*WORD_W +: WORD_W];
      always_comb begin
         pos = '0;
         for (int b = 0; b < WORD_W; b++) begin
            if (wbits[b]) pos = BIT_W'(b);
         end
      end
      assign word_hit[w] = |wbits;
      assign word_pos[w] = pos;
   end

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int w = 0; w < NWORDS; w++) begin
         if (word_hit[w]) begin
            found = 1'b1;
            idx   = IDX_W'(w * WORD_W) | IDX_W'(word_pos[w]);
         end
      end
   end

endmodule

// File: rtl/iau_prio.sv
// Processor priority and class-based request qualification.
module iau_prio #(
   parameter int VEC_W = 8,
   parameter int CLS_W = 4
) (
   input  logic [VEC_W-1:0] tpr,
   input  logic             isr_found,
   input  logic [VEC_W-1:0] isr_hi,
   input  logic             irr_found,
   input  logic [VEC_W-1:0] irr_hi,
   input  logic             sw_en,
   output logic [VEC_W-1:0] ppr,
   output logic             qualify,
   output logic             irq
);
   localparam int LOW_W = VEC_W - CLS_W;

   if (CLS_W < 1 || CLS_W >= VEC_W) begin : g_bad_cfg
      $error("iau_prio: CLS_W must be between 1 and VEC_W-1");
   end

   logic [CLS_W-1:0] tpr_cls, isr_cls, irr_cls, ppr_cls;

   assign tpr_cls = tpr[VEC_W-1 -: CLS_W];
   assign isr_cls = isr_hi[VEC_W-1 -: CLS_W];
   assign irr_cls = irr_hi[VEC_W-1 -: CLS_W];

   always_comb begin
      if (!isr_found || tpr_cls >= isr_cls) ppr = tpr;
      else                                  ppr = {isr_cls, {LOW_W{1'b0}}};
   end

   assign ppr_cls = ppr[VEC_W-1 -: CLS_W];
   assign qualify = irr_found && !((ppr != '0) && (irr_cls <= ppr_cls));
   assign irq     = sw_en && qualify;

endmodule

// File: rtl/intr_accept_unit.sv
module intr_accept_unit
   import iau_pkg::*;
#(
   parameter int              VEC_W    = 8,
   parameter int              CLS_W    = 4,
   parameter int              WORD_W   = 32,
   parameter logic [VEC_W-1:0] SPUR_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arr_valid,
   input  logic [VEC_W-1:0] arr_vector,
   input  logic             arr_level,
   input  logic             tpr_wr,
   input  logic [VEC_W-1:0] tpr_data,
   input  logic             spur_wr,
   input  logic [VEC_W+1:0] spur_data,
   input  logic             ack_req,
   output logic             ack_valid,
   output logic             ack_none,
   output logic [VEC_W-1:0] ack_vector,
   input  logic             eoi_wr,
   output logic             eoi_bcast_valid,
   output logic [VEC_W-1:0] eoi_bcast_vector,
   output logic             irq_pending,
   output logic [VEC_W-1:0] ppr
);
   localparam int NUM_VEC = 1 << VEC_W;

   if (VEC_W + 2 != CTL_W) begin : g_bad_cfg
      $error("intr_accept_unit: control layout needs VEC_W + 2 bits");
   end

   logic [NUM_VEC-1:0] irr, isr, tmr;
   logic [VEC_W-1:0]   tpr, spur_vec;
   logic               sw_en, dir_eoi;

   logic               irr_found, isr_found, qualify;
   logic [VEC_W-1:0]   irr_hi, isr_hi;
   ack_kind_e          ack_kind;

   iau_hi_scan #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) i_irr_scan (
      .bits(irr), .found(irr_found), .idx(irr_hi));

   iau_hi_scan #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) i_isr_scan (
      .bits(isr), .found(isr_found), .idx(isr_hi));

   iau_prio #(.VEC_W(VEC_W), .CLS_W(CLS_W)) i_prio (
      .tpr(tpr), .isr_found(isr_found), .isr_hi(isr_hi),
      .irr_found(irr_found), .irr_hi(irr_hi), .sw_en(sw_en),
      .ppr(ppr), .qualify(qualify), .irq(irq_pending));

   always_comb begin
      if (!sw_en || !irr_found) ack_kind = ACK_NONE;
      else if (!qualify)        ack_kind = ACK_SPUR;
      else                      ack_kind = ACK_GRANT;
   end

   // Per-cycle set/clear masks for the three vector sets
   logic [NUM_VEC-1:0] irr_set, irr_clr, isr_set, isr_clr, tmr_set, tmr_clr;
   logic               grant, retire;

   assign grant  = ack_req && (ack_kind == ACK_GRANT);
   assign retire = eoi_wr && isr_found;

   always_comb begin
      irr_set = '0; irr_clr = '0; isr_set = '0;
      isr_clr = '0; tmr_set = '0; tmr_clr = '0;
      if (arr_valid) begin
         irr_set[arr_vector] = 1'b1;
         if (arr_level) tmr_set[arr_vector] = 1'b1;
         else           tmr_clr[arr_vector] = 1'b1;
      end
      if (grant) begin
         irr_clr[irr_hi] = 1'b1;
         isr_set[irr_hi] = 1'b1;
      end
      if (retire) isr_clr[isr_hi] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr      <= '0;
         isr      <= '0;
         tmr      <= '0;
         tpr      <= '0;
         spur_vec <= SPUR_RST;
         sw_en    <= 1'b0;
         dir_eoi  <= 1'b0;
      end else begin
         irr <= (irr & ~irr_clr) | irr_set;
         isr <= (isr & ~isr_clr) | isr_set;
         tmr <= (tmr & ~tmr_clr) | tmr_set;
         if (tpr_wr) tpr <= tpr_data;
         if (spur_wr) begin
            spur_vec <= spur_data[VEC_W-1:0];
            sw_en    <= spur_data[CTL_EN_BIT];
            dir_eoi  <= spur_data[CTL_DIR_BIT];
         end
      end
   end

   // Registered responses
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_valid        <= 1'b0;
         ack_none         <= 1'b0;
         ack_vector       <= '0;
         eoi_bcast_valid  <= 1'b0;
         eoi_bcast_vector <= '0;
      end else begin
         ack_valid <= ack_req;
         if (ack_req) begin
            ack_none <= (ack_kind == ACK_NONE);
            unique case (ack_kind)
               ACK_GRANT: ack_vector <= irr_hi;
               ACK_SPUR:  ack_vector <= spur_vec;
               default:   ack_vector <= '0;
            endcase
         end
         eoi_bcast_valid <= retire && tmr[isr_hi] && !dir_eoi;
         if (retire) eoi_bcast_vector <= isr_hi;
      end
   end

endmodule

// File: rtl/intr_accept_unit_chk.sv
module intr_accept_unit_chk #(
   parameter int VEC_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    arr_valid,
   input logic [VEC_W-1:0]        arr_vector,
   input logic                    arr_level,
   input logic                    ack_req,
   input logic                    ack_valid,
   input logic                    ack_none,
   input logic [VEC_W-1:0]        ack_vector,
   input logic                    eoi_wr,
   input logic                    eoi_bcast_valid,
   input logic                    irq_pending,
   input logic [VEC_W-1:0]        ppr,
   input logic [VEC_W-1:0]        tpr,
   input logic                    sw_en,
   input logic [(1<<VEC_W)-1:0]   irr,
   input logic [(1<<VEC_W)-1:0]   tmr,
   input logic                    irr_found,
   input logic [VEC_W-1:0]        irr_hi
);
   p_arrive_irr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      arr_valid |=> irr[$past(arr_vector)]);

   p_level_tmr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      arr_valid && arr_level |=> tmr[$past(arr_vector)]);

   p_edge_tmr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      arr_valid && !arr_level |=> !tmr[$past(arr_vector)]);

   p_ppr_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ppr >= tpr);

   p_enable_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_en |-> !irq_pending);

   p_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req && irq_pending |=> ack_valid && !ack_none && (ack_vector == $past(irr_hi)));

   p_ack_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> $past(ack_req));

   p_empty_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req && !irr_found |=> ack_valid && ack_none);

   p_bcast_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_bcast_valid |-> $past(eoi_wr));

endmodule

bind intr_accept_unit intr_accept_unit_chk #(.VEC_W(VEC_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_vector(arr_vector),
   .arr_level(arr_level), .ack_req(ack_req), .ack_valid(ack_valid),
   .ack_none(ack_none), .ack_vector(ack_vector), .eoi_wr(eoi_wr),
   .eoi_bcast_valid(eoi_bcast_valid), .irq_pending(irq_pending), .ppr(ppr),
   .tpr(tpr), .sw_en(sw_en), .irr(irr), .tmr(tmr),
   .irr_found(irr_found), .irr_hi(irr_hi));

// File: tb/test_intr_accept_unit.sv
`timescale 1ns/1ps
module test_intr_accept_unit;
   // Step operations
   localparam logic [2:0] OP_CTL = 3'd0, OP_ARR = 3'd1, OP_TPR = 3'd2,
                          OP_ACK = 3'd3, OP_EOI = 3'd4;
   // Expected kind: ACK 0 grant / 1 spurious / 2 none; EOI 0 quiet / 1 broadcast
   typedef struct packed {
      logic [2:0] op;
      logic [9:0] data;   // ARR: [8] level, [7:0] vector
      logic       irq;
      logic [7:0] ppr;
      logic [1:0] kind;
      logic [7:0] vec;
      logic [3:0] req;    // requirement number printed on failure
   } step_t;

   localparam int NSTEP = 35;
   localparam step_t TAB [NSTEP] = '{
      '{OP_CTL, 10'h13F, 1'b0, 8'h00, 2'd0, 8'h00, 4'd6},  // enable, spurious 0x3F
      '{OP_ARR, 10'h045, 1'b1, 8'h00, 2'd0, 8'h00, 4'd2},  // R2 edge
      '{OP_ARR, 10'h182, 1'b1, 8'h00, 2'd0, 8'h00, 4'd2},  // level
      '{OP_ARR, 10'h021, 1'b1, 8'h00, 2'd0, 8'h00, 4'd2},
      '{OP_ACK, 10'h000, 1'b0, 8'h80, 2'd0, 8'h82, 4'd3},  // R3 highest word wins
      '{OP_ACK, 10'h000, 1'b0, 8'h80, 2'd1, 8'h3F, 4'd8},  // R8 masked -> spurious
      '{OP_TPR, 10'h090, 1'b0, 8'h90, 2'd0, 8'h00, 4'd4},  // R4 task priority wins
      '{OP_TPR, 10'h010, 1'b0, 8'h80, 2'd0, 8'h00, 4'd4},  // in-service class wins
      '{OP_ARR, 10'h1A7, 1'b1, 8'h80, 2'd0, 8'h00, 4'd5},  // R5 class above ppr
      '{OP_ACK, 10'h000, 1'b0, 8'hA0, 2'd0, 8'hA7, 4'd7},  // R7 grant
      '{OP_EOI, 10'h000, 1'b0, 8'h80, 2'd1, 8'hA7, 4'd10}, // R10 level broadcast
      '{OP_EOI, 10'h000, 1'b1, 8'h10, 2'd1, 8'h82, 4'd10},
      '{OP_ACK, 10'h000, 1'b0, 8'h40, 2'd0, 8'h45, 4'd7},
      '{OP_EOI, 10'h000, 1'b1, 8'h10, 2'd0, 8'h00, 4'd11}, // R11 edge: no broadcast
      '{OP_TPR, 10'h000, 1'b1, 8'h00, 2'd0, 8'h00, 4'd4},
      '{OP_ARR, 10'h005, 1'b1, 8'h00, 2'd0, 8'h00, 4'd12}, // R12 low vector
      '{OP_ACK, 10'h000, 1'b0, 8'h20, 2'd0, 8'h21, 4'd3},  // same-word/low-word order
      '{OP_EOI, 10'h000, 1'b1, 8'h00, 2'd0, 8'h00, 4'd5},  // ppr 0 masks nothing
      '{OP_ACK, 10'h000, 1'b0, 8'h00, 2'd0, 8'h05, 4'd12},
      '{OP_ACK, 10'h000, 1'b0, 8'h00, 2'd2, 8'h00, 4'd9},  // R9 empty
      '{OP_EOI, 10'h000, 1'b0, 8'h00, 2'd0, 8'h00, 4'd11},
      '{OP_ARR, 10'h10F, 1'b1, 8'h00, 2'd0, 8'h00, 4'd12},
      '{OP_CTL, 10'h23F, 1'b0, 8'h00, 2'd0, 8'h00, 4'd6},  // R6 disable
      '{OP_ACK, 10'h000, 1'b0, 8'h00, 2'd2, 8'h00, 4'd9},  // disabled -> none
      '{OP_CTL, 10'h33F, 1'b1, 8'h00, 2'd0, 8'h00, 4'd6},
      '{OP_ACK, 10'h000, 1'b0, 8'h00, 2'd0, 8'h0F, 4'd12},
      '{OP_EOI, 10'h000, 1'b0, 8'h00, 2'd0, 8'h00, 4'd10}, // directed: no broadcast
      '{OP_EOI, 10'h000, 1'b0, 8'h00, 2'd0, 8'h00, 4'd10}, // empty in-service
      '{OP_ARR, 10'h000, 1'b1, 8'h00, 2'd0, 8'h00, 4'd12},
      '{OP_ARR, 10'h0FF, 1'b1, 8'h00, 2'd0, 8'h00, 4'd3},
      '{OP_ACK, 10'h000, 1'b0, 8'hF0, 2'd0, 8'hFF, 4'd3},
      '{OP_ACK, 10'h000, 1'b0, 8'hF0, 2'd1, 8'h3F, 4'd8},
      '{OP_EOI, 10'h000, 1'b1, 8'h00, 2'd0, 8'h00, 4'd11},
      '{OP_ACK, 10'h000, 1'b0, 8'h00, 2'd0, 8'h00, 4'd12},
      '{OP_EOI, 10'h000, 1'b0, 8'h00, 2'd0, 8'h00, 4'd11}
   };

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       arr_valid = 0, arr_level = 0, tpr_wr = 0, spur_wr = 0;
   logic       ack_req = 0, eoi_wr = 0;
   logic [7:0] arr_vector = 0, tpr_data = 0;
   logic [9:0] spur_data = 0;
   logic       ack_valid, ack_none, eoi_bcast_valid, irq_pending;
   logic [7:0] ack_vector, eoi_bcast_vector, ppr;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   intr_accept_unit i_intr_accept_unit (
      .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_vector(arr_vector),
      .arr_level(arr_level), .tpr_wr(tpr_wr), .tpr_data(tpr_data),
      .spur_wr(spur_wr), .spur_data(spur_data), .ack_req(ack_req),
      .ack_valid(ack_valid), .ack_none(ack_none), .ack_vector(ack_vector),
      .eoi_wr(eoi_wr), .eoi_bcast_valid(eoi_bcast_valid),
      .eoi_bcast_vector(eoi_bcast_vector), .irq_pending(irq_pending), .ppr(ppr));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Drive one strobe for one cycle; results are sampled at the following negedge
   task automatic do_step(input step_t s);
      @(negedge clk);
      case (s.op)
         OP_CTL: begin spur_wr = 1; spur_data = s.data; end
         OP_ARR: begin arr_valid = 1; arr_vector = s.data[7:0]; arr_level = s.data[8]; end
         OP_TPR: begin tpr_wr = 1; tpr_data = s.data[7:0]; end
         OP_ACK: ack_req = 1;
         default: eoi_wr = 1;
      endcase
      @(negedge clk);
      {spur_wr, arr_valid, tpr_wr, ack_req, eoi_wr} = '0;
   endtask

   task automatic show_step(input step_t s);
      string r;
      r = $sformatf("R%0d", s.req);
      check(irq_pending == s.irq, r, "irq_pending", irq_pending, s.irq);
      check(ppr == s.ppr, r, "ppr", ppr, s.ppr);
      if (s.op == OP_ACK) begin
         check(ack_valid == 1'b1, r, "ack_valid", ack_valid, 1);
         check(ack_none == (s.kind == 2'd2), r, "ack_none", ack_none, s.kind == 2'd2);
         if (s.kind != 2'd2) check(ack_vector == s.vec, r, "ack_vector", ack_vector, s.vec);
      end
      if (s.op == OP_EOI) begin
         check(eoi_bcast_valid == s.kind[0], r, "eoi_bcast_valid", eoi_bcast_valid, s.kind[0]);
         if (s.kind[0]) check(eoi_bcast_vector == s.vec, r, "eoi_bcast_vector",
                              eoi_bcast_vector, s.vec);
      end else begin
         check(eoi_bcast_valid == 1'b0, r, "eoi_bcast_valid idle", eoi_bcast_valid, 0);
      end
   endtask

   task automatic apply_reset;
      @(negedge clk);
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      step_t s;
      apply_reset();
      // R1: reset state
      check(irq_pending == 1'b0, "R1", "irq_pending after reset", irq_pending, 0);
      check(ppr == 8'h00, "R1", "ppr after reset", ppr, 0);
      check(ack_valid == 1'b0, "R1", "ack_valid after reset", ack_valid, 0);

      for (int i = 0; i < NSTEP; i++) begin
         do_step(TAB[i]);
         show_step(TAB[i]);
      end

      // R1: reset in the middle of activity clears pending requests
      s = '{OP_ARR, 10'h190, 1'b1, 8'h00, 2'd0, 8'h00, 4'd1};
      do_step(s);
      check(irq_pending == 1'b1, "R1", "irq before reset", irq_pending, 1);
      apply_reset();
      check(irq_pending == 1'b0, "R1", "irq after reset", irq_pending, 0);
      s = '{OP_CTL, 10'h100, 1'b0, 8'h00, 2'd0, 8'h00, 4'd1};
      do_step(s);
      show_step(s);
      s = '{OP_ACK, 10'h000, 1'b0, 8'h00, 2'd2, 8'h00, 4'd1};
      do_step(s);
      show_step(s);
      // R8 / R1: spurious vector default 0xFF is replaced by control write
      s = '{OP_TPR, 10'h0F0, 1'b0, 8'hF0, 2'd0, 8'h00, 4'd4};
      do_step(s);
      show_step(s);
      s = '{OP_ARR, 10'h0E1, 1'b0, 8'hF0, 2'd0, 8'h00, 4'd5};  // class E <= F masked
      do_step(s);
      show_step(s);
      s = '{OP_ACK, 10'h000, 1'b0, 8'hF0, 2'd1, 8'h00, 4'd8};  // control vector written as 0x00
      do_step(s);
      show_step(s);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule